// File: doc/BRIEF.md
# Global Memory Issue and Return Flow Controller

This block sits between the wavefront pipelines of a compute unit and the global memory path. On the issue side it looks at the head of the queue of executed memory instructions and sorts it into one of two classes. Plain loads and every kind of atomic go to the load class. Stores go to the store class. The head is handed to the translation stage only while its class has fewer than `QSIZE` operations outstanding. At most one request leaves per cycle, and requests leave in queue order.

On the return side, two queues present completed operations: one holds loads and atomics, the other holds stores. At most one of them is retired per cycle, and the load queue always wins. A retire waits for several things: the operation's latency must be done, all its lanes must have finished, the shared memory-to-register bus must be idle, and the originating pipe must be free to take a result. An operation that writes registers must also have the register file's acceptance. Each retire releases one slot of its class and lowers the per-wavefront outstanding totals. It then occupies the bus, and optionally the originating pipe, for times carried in the returning operation.

Top module: `gm_flow_ctrl`

## Requirements
- R1: Operation kinds are encoded 2'b00 load, 2'b01 store, 2'b10 atomic returning data, 2'b11 atomic without return. Every kind other than 2'b01 is load class. An accepted issue raises its class counter (`ld_inflight_o` or `st_inflight_o`) by one at the next clock edge.
- R2: An issue is offered (`mem_valid_o`) only while the class counter of the head is below `QSIZE`. `iss_ready_o` is high only when that condition holds and `mem_ready_i` is high. At most one request is accepted per cycle.
- R3: The load return queue is served first. `stq_pop_o` can be high only in a cycle with `ldq_valid_i` low. At most one pop occurs per cycle.
- R4: A load-queue entry of kind 2'b00 or 2'b10 retires only while `rf_ready_i` is high, and `rf_wr_o` is high in that cycle. Kind 2'b11 retires regardless of `rf_ready_i` and never raises `rf_wr_o`.
- R5: A retire requires the entry's latency-done flag to be high, its lane-pending mask to be all zeros and `bus_busy_o` to be low.
- R6: With `coissue_i` low, a retire requires the wait timer of the entry's pipe to be zero, and the retire loads that timer with the entry's wait value. With `coissue_i` high, pipe timers neither block retires nor get loaded.
- R7: A retire with bus occupancy N holds `bus_busy_o` high and blocks all retires for the following N cycles.
- R8: A retire lowers the counter of its class by one. An issue and a retire of the same class in the same cycle leave that counter unchanged.
- R9: For each wavefront, an accepted issue raises the total count, the read count (kinds other than store) and the write count (kinds other than load). A retire lowers the same counts for the retiring wavefront.
- R10: A decrement of a counter that is already zero, whether a class counter or a wavefront counter, leaves it unchanged except for a same-cycle increment. It also sets `err_o`, which stays high until reset.
- R11: After reset, all counters are zero, `bus_busy_o` is low and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coissue_i | input | 1 | Co-issue return mode; disables pipe wait timers |
| iss_valid_i | input | 1 | Issued-request queue head is valid |
| iss_kind_i | input | 2 | Kind of the head request |
| iss_wf_i | input | WF_W | Wavefront of the head request |
| iss_ready_o | output | 1 | Head accepted (queue pop) this cycle when valid |
| mem_valid_o | output | 1 | Request offered to translation |
| mem_ready_i | input | 1 | Translation can take a request |
| ldq_valid_i | input | 1 | Load return queue head is valid |
| ldq_kind_i | input | 2 | Kind of the load-queue head |
| ldq_wf_i | input | WF_W | Wavefront of the load-queue head |
| ldq_pipe_i | input | PIPE_W | Originating pipe of the load-queue head |
| ldq_lat_done_i | input | 1 | Latency of the load-queue head elapsed |
| ldq_lane_pend_i | input | LANES | Per-lane pending mask of the load-queue head |
| ldq_bus_i | input | OCC_W | Bus occupancy cycles of the load-queue head |
| ldq_wait_i | input | OCC_W | Pipe wait cycles of the load-queue head |
| ldq_pop_o | output | 1 | Load-queue head retired |
| stq_valid_i | input | 1 | Store return queue head is valid |
| stq_wf_i | input | WF_W | Wavefront of the store-queue head |
| stq_pipe_i | input | PIPE_W | Originating pipe of the store-queue head |
| stq_lat_done_i | input | 1 | Latency of the store-queue head elapsed |
| stq_lane_pend_i | input | LANES | Per-lane pending mask of the store-queue head |
| stq_bus_i | input | OCC_W | Bus occupancy cycles of the store-queue head |
| stq_wait_i | input | OCC_W | Pipe wait cycles of the store-queue head |
| stq_pop_o | output | 1 | Store-queue head retired |
| rf_ready_i | input | 1 | Register file accepts the write of the load-queue head |
| rf_wr_o | output | 1 | Register write strobe for a data-returning retire |
| ld_inflight_o | output | CNT_W | Load-class operations in flight |
| st_inflight_o | output | CNT_W | Store-class operations in flight |
| wf_tot_o | output | NUM_WF*CNT_W | Per-wavefront outstanding totals |
| wf_rd_o | output | NUM_WF*CNT_W | Per-wavefront outstanding reads |
| wf_wr_o | output | NUM_WF*CNT_W | Per-wavefront outstanding writes |
| bus_busy_o | output | 1 | Return bus occupied |
| err_o | output | 1 | Sticky counter underflow flag |

## Verification
The bench builds the block with `QSIZE`=3, four wavefronts, two pipes, four lanes and 3-bit timer fields. A limit of three lets the directed part fill the load class and reach its stall within a few cycles, and lets random traffic hit the limit of each class often. Two pipes are enough to show one pipe's wait timer blocking while the other pipe runs, and short timer fields keep bus and pipe occupancy windows overlapping with frequent retire attempts. Four wavefronts give the random phase same-wavefront issue/retire collisions as well as separate ones.

// File: rtl/gm_flow_pkg.sv
`timescale 1ns/1ps
package gm_flow_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_ATR = 2'd2,
    OP_ATN = 2'd3
  } op_kind_e;

  // load class == reads memory
  function automatic logic reads_mem(input logic [1:0] k);
    return k != OP_ST;
  endfunction

  function automatic logic writes_mem(input logic [1:0] k);
    return k != OP_LD;
  endfunction

  function automatic logic rets_data(input logic [1:0] k);
    return (k == OP_LD) || (k == OP_ATR);
  endfunction
endpackage

// File: rtl/gm_io_ctr.sv
`timescale 1ns/1ps
module gm_io_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         udf_o
);
  logic [W-1:0] cnt_q;

  assign udf_o = dec_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (udf_o)             cnt_q <= cnt_q + W'(inc_i);
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + W'(1);
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/gm_cd_timer.sv
`timescale 1ns/1ps
module gm_cd_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         idle_o
);
  logic [W-1:0] cnt_q;

  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= val_i;
    else if (!idle_o) cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/gm_ret_arb.sv
`timescale 1ns/1ps
module gm_ret_arb
  import gm_flow_pkg::*;
#(
  parameter int WF_W     = 2,
  parameter int PIPE_W   = 1,
  parameter int NUM_PIPE = 2,
  parameter int LANES    = 8,
  parameter int OCC_W    = 4
) (
  input  logic                coissue_i,
  input  logic                bus_free_i,
  input  logic [NUM_PIPE-1:0] pipe_free_i,
  input  logic                rf_ready_i,
  input  logic                ldq_valid_i,
  input  logic [1:0]          ldq_kind_i,
  input  logic [WF_W-1:0]     ldq_wf_i,
  input  logic [PIPE_W-1:0]   ldq_pipe_i,
  input  logic                ldq_lat_done_i,
  input  logic [LANES-1:0]    ldq_lane_pend_i,
  input  logic [OCC_W-1:0]    ldq_bus_i,
  input  logic [OCC_W-1:0]    ldq_wait_i,
  input  logic                stq_valid_i,
  input  logic [WF_W-1:0]     stq_wf_i,
  input  logic [PIPE_W-1:0]   stq_pipe_i,
  input  logic                stq_lat_done_i,
  input  logic [LANES-1:0]    stq_lane_pend_i,
  input  logic [OCC_W-1:0]    stq_bus_i,
  input  logic [OCC_W-1:0]    stq_wait_i,
  output logic                ldq_pop_o,
  output logic                stq_pop_o,
  output logic                ret_o,
  output logic [1:0]          ret_kind_o,
  output logic [WF_W-1:0]     ret_wf_o,
  output logic [PIPE_W-1:0]   ret_pipe_o,
  output logic [OCC_W-1:0]    ret_bus_o,
  output logic [OCC_W-1:0]    ret_wait_o,
  output logic                rf_wr_o
);
  logic             use_ld, cand_v, lat_ok, lanes_ok, pipe_ok, rf_ok;
  logic [LANES-1:0] pend;

  always_comb begin
    // strict priority: store queue seen only when load queue is empty
    use_ld     = ldq_valid_i;
    cand_v     = ldq_valid_i || stq_valid_i;
    ret_kind_o = use_ld ? ldq_kind_i     : OP_ST;
    ret_wf_o   = use_ld ? ldq_wf_i       : stq_wf_i;
    ret_pipe_o = use_ld ? ldq_pipe_i     : stq_pipe_i;
    ret_bus_o  = use_ld ? ldq_bus_i      : stq_bus_i;
    ret_wait_o = use_ld ? ldq_wait_i     : stq_wait_i;
    lat_ok     = use_ld ? ldq_lat_done_i : stq_lat_done_i;
    pend       = use_ld ? ldq_lane_pend_i : stq_lane_pend_i;
    lanes_ok   = (pend == '0);
    pipe_ok    = coissue_i || pipe_free_i[ret_pipe_o];
    rf_ok      = !rets_data(ret_kind_o) || rf_ready_i;
    ret_o      = cand_v && lat_ok && lanes_ok && bus_free_i && pipe_ok && rf_ok;
    ldq_pop_o  = ret_o && use_ld;
    stq_pop_o  = ret_o && !use_ld;
    rf_wr_o    = ret_o && rets_data(ret_kind_o);
  end
endmodule

// File: rtl/gm_flow_ctrl.sv
`timescale 1ns/1ps
module gm_flow_ctrl
  import gm_flow_pkg::*;
#(
  parameter int QSIZE    = 4,
  parameter int NUM_WF   = 4,
  parameter int NUM_PIPE = 2,
  parameter int LANES    = 8,
  parameter int CNT_W    = 4,
  parameter int OCC_W    = 4,
  localparam int WF_W    = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
  localparam int PIPE_W  = (NUM_PIPE > 1) ? $clog2(NUM_PIPE) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    coissue_i,
  input  logic                    iss_valid_i,
  input  logic [1:0]              iss_kind_i,
  input  logic [WF_W-1:0]         iss_wf_i,
  output logic                    iss_ready_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  input  logic                    ldq_valid_i,
  input  logic [1:0]              ldq_kind_i,
  input  logic [WF_W-1:0]         ldq_wf_i,
  input  logic [PIPE_W-1:0]       ldq_pipe_i,
  input  logic                    ldq_lat_done_i,
  input  logic [LANES-1:0]        ldq_lane_pend_i,
  input  logic [OCC_W-1:0]        ldq_bus_i,
  input  logic [OCC_W-1:0]        ldq_wait_i,
  output logic                    ldq_pop_o,
  input  logic                    stq_valid_i,
  input  logic [WF_W-1:0]         stq_wf_i,
  input  logic [PIPE_W-1:0]       stq_pipe_i,
  input  logic                    stq_lat_done_i,
  input  logic [LANES-1:0]        stq_lane_pend_i,
  input  logic [OCC_W-1:0]        stq_bus_i,
  input  logic [OCC_W-1:0]        stq_wait_i,
  output logic                    stq_pop_o,
  input  logic                    rf_ready_i,
  output logic                    rf_wr_o,
  output logic [CNT_W-1:0]        ld_inflight_o,
  output logic [CNT_W-1:0]        st_inflight_o,
  output logic [NUM_WF*CNT_W-1:0] wf_tot_o,
  output logic [NUM_WF*CNT_W-1:0] wf_rd_o,
  output logic [NUM_WF*CNT_W-1:0] wf_wr_o,
  output logic                    bus_busy_o,
  output logic                    err_o
);
  localparam logic [CNT_W-1:0] QLIM = CNT_W'(QSIZE);
  localparam int UDF_N = 2 + 3 * NUM_WF;

  logic                iss_ld, room, acc;
  logic                ret;
  logic [1:0]          ret_kind;
  logic [WF_W-1:0]     ret_wf;
  logic [PIPE_W-1:0]   ret_pipe;
  logic [OCC_W-1:0]    ret_bus, ret_wait;
  logic                bus_free;
  logic [NUM_PIPE-1:0] pipe_free;
  logic [UDF_N-1:0]    udf;
  logic                err_q;

  // issue side: per-class throttle
  assign iss_ld      = reads_mem(iss_kind_i);
  assign room        = iss_ld ? (ld_inflight_o < QLIM) : (st_inflight_o < QLIM);
  assign mem_valid_o = iss_valid_i && room;
  assign iss_ready_o = mem_ready_i && room;
  assign acc         = iss_valid_i && iss_ready_o;

  gm_ret_arb #(
    .WF_W(WF_W), .PIPE_W(PIPE_W), .NUM_PIPE(NUM_PIPE), .LANES(LANES), .OCC_W(OCC_W)
  ) u_arb (
    .coissue_i       (coissue_i),
    .bus_free_i      (bus_free),
    .pipe_free_i     (pipe_free),
    .rf_ready_i      (rf_ready_i),
    .ldq_valid_i     (ldq_valid_i),
    .ldq_kind_i      (ldq_kind_i),
    .ldq_wf_i        (ldq_wf_i),
    .ldq_pipe_i      (ldq_pipe_i),
    .ldq_lat_done_i  (ldq_lat_done_i),
    .ldq_lane_pend_i (ldq_lane_pend_i),
    .ldq_bus_i       (ldq_bus_i),
    .ldq_wait_i      (ldq_wait_i),
    .stq_valid_i     (stq_valid_i),
    .stq_wf_i        (stq_wf_i),
    .stq_pipe_i      (stq_pipe_i),
    .stq_lat_done_i  (stq_lat_done_i),
    .stq_lane_pend_i (stq_lane_pend_i),
    .stq_bus_i       (stq_bus_i),
    .stq_wait_i      (stq_wait_i),
    .ldq_pop_o       (ldq_pop_o),
    .stq_pop_o       (stq_pop_o),
    .ret_o           (ret),
    .ret_kind_o      (ret_kind),
    .ret_wf_o        (ret_wf),
    .ret_pipe_o      (ret_pipe),
    .ret_bus_o       (ret_bus),
    .ret_wait_o      (ret_wait),
    .rf_wr_o         (rf_wr_o)
  );

  gm_cd_timer #(.W(OCC_W)) u_bus_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ret),
    .val_i  (ret_bus),
    .idle_o (bus_free)
  );
  assign bus_busy_o = !bus_free;

  for (genvar p = 0; p < NUM_PIPE; p++) begin : g_pipe
    logic ld_p;
    assign ld_p = ret && !coissue_i && (ret_pipe == PIPE_W'(p));
    gm_cd_timer #(.W(OCC_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ld_p),
      .val_i  (ret_wait),
      .idle_o (pipe_free[p])
    );
  end

  gm_io_ctr #(.W(CNT_W)) u_ld_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (acc && iss_ld),
    .dec_i  (ret && reads_mem(ret_kind)),
    .cnt_o  (ld_inflight_o),
    .udf_o  (udf[0])
  );

  gm_io_ctr #(.W(CNT_W)) u_st_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (acc && !iss_ld),
    .dec_i  (ret && !reads_mem(ret_kind)),
    .cnt_o  (st_inflight_o),
    .udf_o  (udf[1])
  );

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
    logic iss_hit, ret_hit;
    assign iss_hit = acc && (iss_wf_i == WF_W'(w));
    assign ret_hit = ret && (ret_wf == WF_W'(w));

    gm_io_ctr #(.W(CNT_W)) u_tot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (iss_hit),
      .dec_i  (ret_hit),
      .cnt_o  (wf_tot_o[w*CNT_W +: CNT_W]),
      .udf_o  (udf[2+3*w])
    );
    gm_io_ctr #(.W(CNT_W)) u_rd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (iss_hit && reads_mem(iss_kind_i)),
      .dec_i  (ret_hit && reads_mem(ret_kind)),
      .cnt_o  (wf_rd_o[w*CNT_W +: CNT_W]),
      .udf_o  (udf[3+3*w])
    );
    gm_io_ctr #(.W(CNT_W)) u_wr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (iss_hit && writes_mem(iss_kind_i)),
      .dec_i  (ret_hit && writes_mem(ret_kind)),
      .cnt_o  (wf_wr_o[w*CNT_W +: CNT_W]),
      .udf_o  (udf[4+3*w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (|udf) err_q <= 1'b1;
  end
  assign err_o = err_q;
endmodule

// File: rtl/gm_flow_ctrl_chk.sv
`timescale 1ns/1ps
module gm_flow_ctrl_chk #(
  parameter int QSIZE = 4,
  parameter int LANES = 8,
  parameter int CNT_W = 4,
  parameter int OCC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iss_valid_i,
  input logic [1:0]       iss_kind_i,
  input logic             iss_ready_o,
  input logic [CNT_W-1:0] ld_inflight_o,
  input logic [CNT_W-1:0] st_inflight_o,
  input logic             ldq_valid_i,
  input logic [1:0]       ldq_kind_i,
  input logic             ldq_lat_done_i,
  input logic [LANES-1:0] ldq_lane_pend_i,
  input logic [OCC_W-1:0] ldq_bus_i,
  input logic             stq_lat_done_i,
  input logic [LANES-1:0] stq_lane_pend_i,
  input logic [OCC_W-1:0] stq_bus_i,
  input logic             rf_ready_i,
  input logic             ldq_pop_o,
  input logic             stq_pop_o,
  input logic             bus_busy_o,
  input logic             err_o
);
  p_one_ret_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ldq_pop_o && stq_pop_o));

  p_ld_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stq_pop_o |-> !ldq_valid_i);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_inflight_o <= QSIZE) && (st_inflight_o <= QSIZE));

  p_ld_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o && iss_kind_i != 2'd1) |-> (ld_inflight_o < QSIZE));

  p_st_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_ready_o && iss_kind_i == 2'd1) |-> (st_inflight_o < QSIZE));

  p_rf_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldq_pop_o && (ldq_kind_i == 2'd0 || ldq_kind_i == 2'd2)) |-> rf_ready_i);

  p_ld_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldq_pop_o |-> (ldq_lat_done_i && ldq_lane_pend_i == '0 && !bus_busy_o));

  p_st_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stq_pop_o |-> (stq_lat_done_i && stq_lane_pend_i == '0 && !bus_busy_o));

  p_ld_bus_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldq_pop_o && ldq_bus_i != '0) |=> bus_busy_o);

  p_st_bus_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stq_pop_o && stq_bus_i != '0) |=> bus_busy_o);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind gm_flow_ctrl gm_flow_ctrl_chk #(
  .QSIZE(QSIZE), .LANES(LANES), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .iss_valid_i     (iss_valid_i),
  .iss_kind_i      (iss_kind_i),
  .iss_ready_o     (iss_ready_o),
  .ld_inflight_o   (ld_inflight_o),
  .st_inflight_o   (st_inflight_o),
  .ldq_valid_i     (ldq_valid_i),
  .ldq_kind_i      (ldq_kind_i),
  .ldq_lat_done_i  (ldq_lat_done_i),
  .ldq_lane_pend_i (ldq_lane_pend_i),
  .ldq_bus_i       (ldq_bus_i),
  .stq_lat_done_i  (stq_lat_done_i),
  .stq_lane_pend_i (stq_lane_pend_i),
  .stq_bus_i       (stq_bus_i),
  .rf_ready_i      (rf_ready_i),
  .ldq_pop_o       (ldq_pop_o),
  .stq_pop_o       (stq_pop_o),
  .bus_busy_o      (bus_busy_o),
  .err_o           (err_o)
);

// File: tb/gm_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module gm_flow_ctrl_tb_top;
  localparam int QS = 3;
  localparam int NW = 4;
  localparam int NP = 2;
  localparam int LN = 4;
  localparam int CW = 4;
  localparam int OW = 3;
  localparam int WW = 2;
  localparam int PW = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic coissue, iss_valid, mem_ready, ldq_valid, ldq_lat, stq_valid, stq_lat, rf_ready;
  logic [1:0] iss_kind, ldq_kind;
  logic [WW-1:0] iss_wf, ldq_wf, stq_wf;
  logic [PW-1:0] ldq_pipe, stq_pipe;
  logic [LN-1:0] ldq_pend, stq_pend;
  logic [OW-1:0] ldq_bus, ldq_wait, stq_bus, stq_wait;
  logic iss_ready, mem_valid, ldq_pop, stq_pop, rf_wr, bus_busy, err;
  logic [CW-1:0] ld_inf, st_inf;
  logic [NW*CW-1:0] wf_tot, wf_rd, wf_wr;

  gm_flow_ctrl #(
    .QSIZE(QS), .NUM_WF(NW), .NUM_PIPE(NP), .LANES(LN), .CNT_W(CW), .OCC_W(OW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .coissue_i(coissue),
    .iss_valid_i(iss_valid), .iss_kind_i(iss_kind), .iss_wf_i(iss_wf),
    .iss_ready_o(iss_ready), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .ldq_valid_i(ldq_valid), .ldq_kind_i(ldq_kind), .ldq_wf_i(ldq_wf), .ldq_pipe_i(ldq_pipe),
    .ldq_lat_done_i(ldq_lat), .ldq_lane_pend_i(ldq_pend), .ldq_bus_i(ldq_bus),
    .ldq_wait_i(ldq_wait), .ldq_pop_o(ldq_pop),
    .stq_valid_i(stq_valid), .stq_wf_i(stq_wf), .stq_pipe_i(stq_pipe),
    .stq_lat_done_i(stq_lat), .stq_lane_pend_i(stq_pend), .stq_bus_i(stq_bus),
    .stq_wait_i(stq_wait), .stq_pop_o(stq_pop),
    .rf_ready_i(rf_ready), .rf_wr_o(rf_wr),
    .ld_inflight_o(ld_inf), .st_inflight_o(st_inf),
    .wf_tot_o(wf_tot), .wf_rd_o(wf_rd), .wf_wr_o(wf_wr),
    .bus_busy_o(bus_busy), .err_o(err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int m_ldc, m_stc, m_bus;
  int m_tot[NW], m_rd[NW], m_wr[NW], m_pipe[NP];
  int oc[NW][4];
  bit m_err;
  bit l_ir, l_mv, l_lp, l_sp, l_rw;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int c, input bit i, input bit d);
    if (d && c == 0) return c + int'(i);
    return c + int'(i) - int'(d);
  endfunction

  function automatic bit rets(input logic [1:0] k);
    return (k == 2'd0) || (k == 2'd2);
  endfunction

  task automatic model_reset();
    m_ldc = 0; m_stc = 0; m_bus = 0; m_err = 0;
    for (int w = 0; w < NW; w++) begin
      m_tot[w] = 0; m_rd[w] = 0; m_wr[w] = 0;
      for (int k = 0; k < 4; k++) oc[w][k] = 0;
    end
    for (int p = 0; p < NP; p++) m_pipe[p] = 0;
  endtask

  task automatic idle();
    iss_valid = 0; iss_kind = 0; iss_wf = 0; mem_ready = 1;
    ldq_valid = 0; ldq_kind = 0; ldq_wf = 0; ldq_pipe = 0; ldq_lat = 1; ldq_pend = 0;
    ldq_bus = 0; ldq_wait = 0;
    stq_valid = 0; stq_wf = 0; stq_pipe = 0; stq_lat = 1; stq_pend = 0;
    stq_bus = 0; stq_wait = 0; rf_ready = 1;
  endtask

  task automatic chk_regs();
    chk("R1 ld_inflight", int'(ld_inf), m_ldc);
    chk("R1 st_inflight", int'(st_inf), m_stc);
    for (int w = 0; w < NW; w++) begin
      chk("R9 wf_tot", int'(wf_tot[w*CW +: CW]), m_tot[w]);
      chk("R9 wf_rd", int'(wf_rd[w*CW +: CW]), m_rd[w]);
      chk("R9 wf_wr", int'(wf_wr[w*CW +: CW]), m_wr[w]);
    end
    chk("R7 bus_busy", int'(bus_busy), int'(m_bus != 0));
    chk("R10 err", int'(err), int'(m_err));
  endtask

  // inputs set at a negedge; checks combinational outputs, steps the model, checks registers
  task automatic cyc();
    bit iss_ld, room, acc, ok_l, ok_s, e_lp, e_sp, ret, e_rw;
    logic [1:0] rk; int rw, rp, rb, rt;
    #1;
    iss_ld = (iss_kind != 2'd1);
    room = iss_ld ? (m_ldc < QS) : (m_stc < QS);
    acc = iss_valid && mem_ready && room;
    ok_l = ldq_lat && (ldq_pend == 0) && (m_bus == 0) &&
           (coissue || m_pipe[ldq_pipe] == 0) && (!rets(ldq_kind) || rf_ready);
    ok_s = stq_lat && (stq_pend == 0) && (m_bus == 0) && (coissue || m_pipe[stq_pipe] == 0);
    e_lp = ldq_valid && ok_l;
    e_sp = !ldq_valid && stq_valid && ok_s;
    ret = e_lp || e_sp;
    e_rw = e_lp && rets(ldq_kind);
    rk = e_lp ? ldq_kind : 2'd1;
    rw = e_lp ? int'(ldq_wf) : int'(stq_wf);
    rp = e_lp ? int'(ldq_pipe) : int'(stq_pipe);
    rb = e_lp ? int'(ldq_bus) : int'(stq_bus);
    rt = e_lp ? int'(ldq_wait) : int'(stq_wait);
    l_ir = iss_ready; l_mv = mem_valid; l_lp = ldq_pop; l_sp = stq_pop; l_rw = rf_wr;
    chk("R2 iss_ready", int'(iss_ready), int'(mem_ready && room));
    chk("R2 mem_valid", int'(mem_valid), int'(iss_valid && room));
    chk("R3 ldq_pop", int'(ldq_pop), int'(e_lp));
    chk("R3 stq_pop", int'(stq_pop), int'(e_sp));
    chk("R4 rf_wr", int'(rf_wr), int'(e_rw));
    // next state
    if ((ret && rk != 2'd1 && m_ldc == 0) || (ret && rk == 2'd1 && m_stc == 0)) m_err = 1;
    m_ldc = nxt(m_ldc, acc && iss_ld, ret && rk != 2'd1);
    m_stc = nxt(m_stc, acc && !iss_ld, ret && rk == 2'd1);
    for (int w = 0; w < NW; w++) begin
      bit ih, rh;
      ih = acc && (int'(iss_wf) == w);
      rh = ret && (rw == w);
      if (rh && (m_tot[w] == 0 || (rk != 2'd1 && m_rd[w] == 0) || (rk != 2'd0 && m_wr[w] == 0)))
        m_err = 1;
      m_tot[w] = nxt(m_tot[w], ih, rh);
      m_rd[w]  = nxt(m_rd[w], ih && iss_kind != 2'd1, rh && rk != 2'd1);
      m_wr[w]  = nxt(m_wr[w], ih && iss_kind != 2'd0, rh && rk != 2'd0);
    end
    for (int p = 0; p < NP; p++) begin
      if (ret && !coissue && rp == p) m_pipe[p] = rt;
      else if (m_pipe[p] > 0) m_pipe[p]--;
    end
    if (ret) m_bus = rb;
    else if (m_bus > 0) m_bus--;
    if (acc) oc[iss_wf][iss_kind]++;
    if (ret && oc[rw][rk] > 0) oc[rw][rk]--;
    @(posedge clk);
    @(negedge clk);
    chk_regs();
  endtask

  task automatic do_reset();
    rst_ni = 0;
    idle();
    coissue = 1;
    repeat (3) @(negedge clk);
    model_reset();
    rst_ni = 1;
  endtask

  task automatic rnd_inputs();
    int w, k;
    idle();
    if ($urandom % 8 == 0) coissue = ~coissue;
    iss_valid = ($urandom % 2) == 1;
    iss_kind = 2'($urandom % 4);
    iss_wf = WW'($urandom % NW);
    mem_ready = ($urandom % 4) != 0;
    w = $urandom % NW;
    k = $urandom % 3;
    k = (k == 0) ? 0 : k + 1;
    ldq_kind = 2'(k); ldq_wf = WW'(w); ldq_pipe = PW'($urandom % NP);
    ldq_valid = (oc[w][k] > 0) && ($urandom % 4 != 0);
    ldq_lat = ($urandom % 4) != 0;
    ldq_pend = ($urandom % 4 == 0) ? LN'($urandom) : '0;
    ldq_bus = OW'($urandom % 4); ldq_wait = OW'($urandom % 5);
    w = $urandom % NW;
    stq_wf = WW'(w); stq_pipe = PW'($urandom % NP);
    stq_valid = (oc[w][1] > 0) && ($urandom % 3 != 0);
    stq_lat = ($urandom % 4) != 0;
    stq_pend = ($urandom % 4 == 0) ? LN'($urandom) : '0;
    stq_bus = OW'($urandom % 4); stq_wait = OW'($urandom % 5);
    rf_ready = ($urandom % 3) != 0;
  endtask

  task automatic issue(input logic [1:0] k, input int w);
    idle();
    iss_valid = 1; iss_kind = k; iss_wf = WW'(w);
    cyc();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    // R11: reset state
    chk("R11 ld_inflight", int'(ld_inf), 0);
    chk("R11 bus_busy", int'(bus_busy), 0);
    chk("R11 err", int'(err), 0);
    chk_regs();

    // R1/R2: fill load class, then stall
    repeat (QS) issue(2'd0, 0);
    chk("R1 load class full", int'(ld_inf), QS);
    idle(); iss_valid = 1; iss_kind = 2'd2; cyc();
    chk("R2 stall at limit", int'(l_ir), 0);
    chk("R2 no offer at limit", int'(l_mv), 0);
    issue(2'd1, 1);
    chk("R2 store class independent", int'(st_inf), 1);

    // R3: load queue first
    idle(); coissue = 1;
    ldq_valid = 1; ldq_kind = 2'd0; ldq_wf = 0;
    stq_valid = 1; stq_wf = 1;
    cyc();
    chk("R3 load wins", int'(l_lp), 1);
    chk("R3 store waits", int'(l_sp), 0);
    ldq_lat = 0; cyc();
    chk("R3 store blocked by load head", int'(l_sp), 0);
    chk("R5 latency gate", int'(l_lp), 0);
    ldq_valid = 0; ldq_lat = 1; cyc();
    chk("R3 store after load empty", int'(l_sp), 1);

    // R4: register file gate, atomic without return
    issue(2'd3, 2);
    chk("R9 atomic rd", int'(wf_rd[2*CW +: CW]), 1);
    chk("R9 atomic wr", int'(wf_wr[2*CW +: CW]), 1);
    idle(); ldq_valid = 1; ldq_kind = 2'd0; ldq_wf = 0; rf_ready = 0; cyc();
    chk("R4 load needs rf", int'(l_lp), 0);
    ldq_kind = 2'd3; ldq_wf = 2; cyc();
    chk("R4 no-return atomic ignores rf", int'(l_lp), 1);
    chk("R4 no rf write", int'(l_rw), 0);
    chk("R9 atomic retired", int'(wf_tot[2*CW +: CW]), 0);
    idle(); ldq_valid = 1; ldq_pend = 4'b0100; cyc();
    chk("R5 lane pending gate", int'(l_lp), 0);

    // R7: bus occupancy
    idle(); ldq_valid = 1; ldq_kind = 2'd0; ldq_wf = 0; ldq_bus = 3'd3; cyc();
    chk("R7 retire", int'(l_lp), 1);
    chk("R7 busy after retire", int'(bus_busy), 1);
    ldq_bus = 0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R7 blocked while busy", int'(l_lp), 0);
    end
    cyc();
    chk("R7 retire after window", int'(l_lp), 1);

    // R6: pipe wait timer
    issue(2'd1, 3);
    issue(2'd1, 3);
    idle(); coissue = 0; stq_valid = 1; stq_wf = 3; stq_pipe = 0; stq_wait = 3'd3; cyc();
    chk("R6 first store", int'(l_sp), 1);
    stq_wait = 0; cyc();
    chk("R6 pipe timer blocks", int'(l_sp), 0);
    coissue = 1; cyc();
    chk("R6 co-issue ignores timer", int'(l_sp), 1);

    // R8: same-cycle issue and retire of one class
    issue(2'd0, 1);
    idle(); iss_valid = 1; iss_kind = 2'd0; iss_wf = 1;
    ldq_valid = 1; ldq_kind = 2'd0; ldq_wf = 1; cyc();
    chk("R8 issue accepted", int'(l_ir), 1);
    chk("R8 retire happened", int'(l_lp), 1);
    chk("R8 counter unchanged", int'(ld_inf), 1);
    chk("R9 wf total unchanged", int'(wf_tot[1*CW +: CW]), 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      rnd_inputs();
      cyc();
    end

    // R10: underflow
    do_reset();
    @(negedge clk);
    idle(); stq_valid = 1; stq_wf = 0; cyc();
    chk("R10 underflow sets err", int'(err), 1);
    chk("R10 counter held", int'(st_inf), 0);
    idle(); cyc();
    chk("R10 err sticky", int'(err), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule